// File: doc/BRIEF.md
# Four-Channel DMA Sequencer

This block moves data between I/O devices and memory without the processor's involvement. It supports four request channels. Each channel has a 16-bit memory address and a 16-bit control word. The control word packs a 14-bit transfer count together with a 2-bit transfer kind. A single mode byte sets four things: which channels may run, whether priority is fixed or rotates, whether write strobes are stretched, and whether a channel shuts itself off when its count runs out. The mode byte can also make channel 2 refill itself from channel 3 when its count runs out.

The processor programs the block through a small byte-wide register port. Peripherals raise request lines. The sequencer picks one pending, enabled channel and raises a hold request toward the bus owner. Once hold is acknowledged, it runs exactly one transfer: it drives the channel's address, an acknowledge for that channel, and the memory and I/O strobes the transfer kind calls for. It then releases the bus. The address steps up by one and the count steps down by one after each transfer. When the count reaches zero, a terminal-count pulse goes out and a sticky flag is set. The processor collects these flags with a clear-on-read status byte.

The sequencer states are IDLE (arbitrate), HREQ (hold requested, waiting for acknowledge), ADDR (address and acknowledge out, no strobes), XFR1 (read strobe, plus the early write strobe when stretching) and XFR2 (read and write strobes; registers update at its end). The transitions are:
- IDLE to HREQ when an eligible request exists.
- HREQ to ADDR on hold acknowledge.
- ADDR to XFR1, then XFR1 to XFR2, unconditionally.
- XFR2 back to IDLE.

Top module: `dmac_top`

## Requirements
- R1: After reset, hold_req, dack, all four strobes and tc are low, the mode byte is zero (every channel disabled), and a status read returns 0.
- R2: Register port map:
  - cpu_addr 2n selects channel n's address and 2n+1 its control word.
  - cpu_addr 8 writes the mode byte and reads status.
  - A 16-bit register takes two writes, low byte first, steered by one shared byte pointer.
  - Any mode write returns that pointer to the low byte.
- R3: An eligible request seen in IDLE raises hold_req on the next cycle. After hold_ack, the winning channel's dack bit (one-hot, bit n for channel n) and its address on mem_addr are held for three cycles. The grant covers exactly one transfer, after which hold_req drops for at least one cycle.
- R4: Control word bits 15..14 give the kind:
  - 2'b10 (read) asserts mem_rd and io_wr.
  - 2'b01 (write) asserts io_rd and mem_wr.
  - 2'b00 (verify) asserts no strobe.
  - The read-side strobe is high in the 2nd and 3rd acknowledged cycles, and the write-side strobe in the 3rd.
- R5: With mode bit 5 set, the write-side strobe is also high in the 2nd acknowledged cycle, overlapping the read-side strobe for one extra cycle.
- R6: After each transfer, the channel address increases by 1 (wrapping at 16 bits) and the 14-bit count decreases by 1.
- R7: A transfer started with count 1 drives tc high in all three acknowledged cycles and sets status bit n. A status read returns the flags and clears them.
- R8: With mode bit 6 set, a channel's enable bit clears at its terminal count, and its further requests are ignored.
- R9: With mode bit 4 clear, the lowest-numbered eligible channel wins.
- R10: With mode bit 4 set, the channel after the last one served has the highest priority, continuing in ascending order with wrap-around.
- R11: With mode bit 7 set, channel 3 never gets a grant. At channel 2's terminal count, channel 3's address and control word are copied into channel 2 and status bit 4 is set. Channel 2 stays enabled even if mode bit 6 is set.
- R12: A request on a channel whose mode enable bit (bits 3..0) is clear gets no hold request and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 4 | Register select |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Status byte during a status read, else 0 |
| dreq | input | 4 | Per-channel transfer requests |
| hold_ack | input | 1 | Bus granted to the sequencer |
| hold_req | output | 1 | Bus wanted by the sequencer |
| dack | output | 4 | One-hot channel acknowledge |
| mem_addr | output | 16 | Transfer memory address, 0 when inactive |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal-count marker for the final transfer |

## Verification
The assertions make two assumptions about the environment:
- Once hold_ack rises, it stays high for as long as hold_req does.
- The mode byte is not rewritten while a transfer is in flight. Otherwise the stretch bit and the channel-3 exclusion could change in the middle of a transfer.

The bench's bus-owner model copies hold_req onto hold_ack one cycle later. The bench also waits for every expected transfer to finish before it writes the mode byte or programs a channel. Every count it loads is at least 1, so the 14-bit count never wraps below zero.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
    localparam int NCH        = 4;
    localparam int CH_W       = $clog2(NCH);
    localparam int WORD_W     = 16;
    localparam int CNT_W      = 14;
    localparam int RA_W       = 4;
    localparam int STAT_SEL   = 2 * NCH;
    localparam int M_ROT      = 4;
    localparam int M_EXT      = 5;
    localparam int M_STOP     = 6;
    localparam int M_RELOAD   = 7;
    localparam int RELOAD_DST = 2;
    localparam int RELOAD_SRC = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HREQ, ST_ADDR, ST_XFR1, ST_XFR2
    } seq_state_e;

    typedef enum logic [1:0] {
        XK_VERIFY = 2'b00,
        XK_WRITE  = 2'b01,
        XK_READ   = 2'b10,
        XK_RSVD   = 2'b11
    } xfer_kind_e;
endpackage

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
    import dmac_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_we,
    input  logic                          cpu_re,
    input  logic [RA_W-1:0]               cpu_addr,
    input  logic [7:0]                    cpu_wdata,
    output logic [7:0]                    cpu_rdata,
    input  logic                          xfer_done,
    input  logic [CH_W-1:0]               xfer_ch,
    output logic [7:0]                    mode,
    output logic [NCH-1:0][WORD_W-1:0]    ch_addr,
    output logic [NCH-1:0][WORD_W-1:0]    ch_word
);
    logic          byte_hi;
    logic [NCH:0]  status;
    logic          stat_hit;
    logic          at_tc;
    logic          reload_hit;
    logic [CH_W-1:0] wsel;

    assign stat_hit   = (cpu_addr == RA_W'(STAT_SEL));
    assign wsel       = cpu_addr[CH_W:1];
    assign at_tc      = (ch_word[xfer_ch][CNT_W-1:0] == CNT_W'(1));
    assign reload_hit = mode[M_RELOAD] && (xfer_ch == CH_W'(RELOAD_DST));

    always_comb begin
        cpu_rdata = '0;
        if (cpu_re && stat_hit) cpu_rdata = 8'(status);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= '0;
            status  <= '0;
            byte_hi <= 1'b0;
            ch_addr <= '0;
            ch_word <= '0;
        end else begin
            if (cpu_re && stat_hit) status <= '0;
            if (cpu_we) begin
                if (stat_hit) begin
                    mode    <= cpu_wdata;
                    byte_hi <= 1'b0;
                end else if (cpu_addr < RA_W'(STAT_SEL)) begin
                    byte_hi <= ~byte_hi;
                    if (cpu_addr[0]) begin
                        if (byte_hi) ch_word[wsel][15:8] <= cpu_wdata;
                        else         ch_word[wsel][7:0]  <= cpu_wdata;
                    end else begin
                        if (byte_hi) ch_addr[wsel][15:8] <= cpu_wdata;
                        else         ch_addr[wsel][7:0]  <= cpu_wdata;
                    end
                end
            end
            if (xfer_done) begin
                ch_addr[xfer_ch]            <= ch_addr[xfer_ch] + 1'b1;
                ch_word[xfer_ch][CNT_W-1:0] <= ch_word[xfer_ch][CNT_W-1:0] - 1'b1;
                if (at_tc) begin
                    status[xfer_ch] <= 1'b1;
                    if (reload_hit) begin
                        ch_addr[RELOAD_DST] <= ch_addr[RELOAD_SRC];
                        ch_word[RELOAD_DST] <= ch_word[RELOAD_SRC];
                        status[NCH]         <= 1'b1;
                    end else if (mode[M_STOP]) begin
                        mode[xfer_ch] <= 1'b0;
                    end
                end
            end
        end
    end

    AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && stat_hit) |=> !byte_hi);                                // R2
    AST_FLAG_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && at_tc) |=> status[$past(xfer_ch)]);                  // R7
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && at_tc && mode[M_STOP] && !reload_hit && !cpu_we)
        |=> !mode[$past(xfer_ch)]);                                        // R8
endmodule

// File: rtl/dmac_arb.sv
`timescale 1ns/1ps
module dmac_arb
    import dmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  req,
    input  logic            rotate,
    input  logic            served,
    input  logic [CH_W-1:0] served_ch,
    output logic            gnt_valid,
    output logic [CH_W-1:0] gnt_ch
);
    logic [CH_W-1:0] head_q;
    logic [CH_W-1:0] top;
    logic [CH_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n)      head_q <= '0;
        else if (served) head_q <= served_ch + 1'b1;
    end

    always_comb begin
        top       = rotate ? head_q : '0;
        gnt_valid = |req;
        gnt_ch    = '0;
        idx       = '0;
        for (int off = NCH - 1; off >= 0; off--) begin
            idx = top + CH_W'(off);
            if (req[idx]) gnt_ch = idx;
        end
    end

    AST_GNT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_ch]);                                        // R9
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !rotate)
        |-> ((req & ((NCH'(1) << gnt_ch) - NCH'(1))) == '0));              // R9
endmodule

// File: rtl/dmac_fsm.sv
`timescale 1ns/1ps
module dmac_fsm
    import dmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gnt_valid,
    input  logic [CH_W-1:0] gnt_ch,
    input  logic            hold_ack,
    input  logic [1:0]      kind,
    input  logic            ext_wr,
    input  logic            last_xfer,
    output logic            hold_req,
    output logic [NCH-1:0]  dack,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr,
    output logic            tc,
    output logic            xfer_done,
    output logic            busy,
    output logic [CH_W-1:0] cur_ch
);
    seq_state_e state_q, state_d;
    logic rd_ph, wr_ph;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_ch  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && gnt_valid) cur_ch <= gnt_ch;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (gnt_valid) state_d = ST_HREQ;
            ST_HREQ: if (hold_ack)  state_d = ST_ADDR;
            ST_ADDR: state_d = ST_XFR1;
            ST_XFR1: state_d = ST_XFR2;
            ST_XFR2: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_req  = 1'b1;
        busy      = 1'b0;
        rd_ph     = 1'b0;
        wr_ph     = 1'b0;
        xfer_done = 1'b0;
        unique case (state_q)
            ST_IDLE: hold_req = 1'b0;
            ST_HREQ: ;
            ST_ADDR: busy = 1'b1;
            ST_XFR1: begin
                busy  = 1'b1;
                rd_ph = 1'b1;
                wr_ph = ext_wr;
            end
            ST_XFR2: begin
                busy      = 1'b1;
                rd_ph     = 1'b1;
                wr_ph     = 1'b1;
                xfer_done = 1'b1;
            end
            default: hold_req = 1'b0;
        endcase
        dack   = busy ? (NCH'(1) << cur_ch) : '0;
        tc     = busy && last_xfer;
        mem_rd = rd_ph && (kind == XK_READ);
        io_wr  = wr_ph && (kind == XK_READ);
        io_rd  = rd_ph && (kind == XK_WRITE);
        mem_wr = wr_ph && (kind == XK_WRITE);
    end

    AST_ONE_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));                                                   // R3
    AST_DACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |-> (hold_req && hold_ack));                          // R3
    AST_RELEASE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (!hold_req && dack == '0));                          // R3
    AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(io_rd && io_wr));                         // R4
    AST_WR_INSIDE_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || io_wr) |-> (mem_rd || io_rd));                          // R5
    AST_TC_WITH_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (dack != '0));                                              // R7
endmodule

// File: rtl/dmac_top.sv
`timescale 1ns/1ps
module dmac_top
    import dmac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_we,
    input  logic                  cpu_re,
    input  logic [RA_W-1:0]       cpu_addr,
    input  logic [7:0]            cpu_wdata,
    output logic [7:0]            cpu_rdata,
    input  logic [NCH-1:0]        dreq,
    input  logic                  hold_ack,
    output logic                  hold_req,
    output logic [NCH-1:0]        dack,
    output logic [WORD_W-1:0]     mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic                  io_rd,
    output logic                  io_wr,
    output logic                  tc
);
    logic [7:0]                 mode;
    logic [NCH-1:0][WORD_W-1:0] ch_addr;
    logic [NCH-1:0][WORD_W-1:0] ch_word;
    logic [NCH-1:0]             reload_mask;
    logic [NCH-1:0]             elig;
    logic                       gnt_valid;
    logic [CH_W-1:0]            gnt_ch;
    logic [CH_W-1:0]            cur_ch;
    logic                       busy;
    logic                       xfer_done;
    logic [1:0]                 kind;
    logic                       last_xfer;

    assign reload_mask = mode[M_RELOAD] ? (NCH'(1) << RELOAD_SRC) : '0;
    assign elig        = dreq & mode[NCH-1:0] & ~reload_mask;
    assign kind        = ch_word[cur_ch][WORD_W-1 -: 2];
    assign last_xfer   = (ch_word[cur_ch][CNT_W-1:0] == CNT_W'(1));
    assign mem_addr    = busy ? ch_addr[cur_ch] : '0;

    dmac_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .xfer_done(xfer_done), .xfer_ch(cur_ch),
        .mode(mode), .ch_addr(ch_addr), .ch_word(ch_word)
    );

    dmac_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .req(elig), .rotate(mode[M_ROT]),
        .served(xfer_done), .served_ch(cur_ch),
        .gnt_valid(gnt_valid), .gnt_ch(gnt_ch)
    );

    dmac_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .gnt_valid(gnt_valid), .gnt_ch(gnt_ch), .hold_ack(hold_ack),
        .kind(kind), .ext_wr(mode[M_EXT]), .last_xfer(last_xfer),
        .hold_req(hold_req), .dack(dack),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .tc(tc), .xfer_done(xfer_done), .busy(busy), .cur_ch(cur_ch)
    );

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));                      // R6
    AST_SRC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[M_RELOAD] && !busy) |=> !dack[RELOAD_SRC]);                  // R11
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hold_req && (elig == '0)) |=> !hold_req);               // R12
endmodule

// File: tb/dmac_top_tb.sv
`timescale 1ns/1ps
module dmac_top_tb;
    typedef struct {
        int         ch;
        logic [15:0] addr;
        logic [1:0]  kind;
        bit          tc;
        bit          ext;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0, cpu_re = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  dreq;
    logic        hold_ack = 1'b0;
    logic        hold_req;
    logic [3:0]  dack;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, tc;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;
    int pend[4] = '{0, 0, 0, 0};
    xfer_t q[$];

    logic [15:0] m_addr[4];
    logic [13:0] m_cnt[4];
    logic [1:0]  m_kind[4];
    logic [7:0]  m_mode = '0;
    logic [4:0]  m_stat = '0;

    always #2 clk = ~clk;

    always_comb for (int i = 0; i < 4; i++) dreq[i] = (pend[i] > 0);

    dmac_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .dreq(dreq), .hold_ack(hold_ack), .hold_req(hold_req), .dack(dack),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .tc(tc)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bus owner: acknowledge follows request by one cycle
    initial forever begin
        @(negedge clk);
        hold_ack = hold_req;
    end

    // monitor / scoreboard consumer
    initial begin
        int    phase;
        xfer_t cur;
        logic [3:0] exp_s, got_s;
        bit rd, wr;
        phase = -1;
        forever begin
            @(negedge clk);
            if (!rst_n || dack == 4'b0) continue;
            if (phase < 0) begin
                if (q.size() == 0) begin
                    check(0, "R12", "unexpected dack", int'(dack), 0);
                    continue;
                end
                cur   = q[0];
                phase = 0;
                check(dack == (4'b1 << cur.ch), "R3", "dack channel", int'(dack), 1 << cur.ch);
                check(mem_addr == cur.addr, "R6", "mem_addr", int'(mem_addr), int'(cur.addr));
            end else begin
                phase++;
                check(dack == (4'b1 << cur.ch), "R3", "dack held", int'(dack), 1 << cur.ch);
            end
            rd = (phase >= 1);
            wr = (phase == 2) || (cur.ext && phase == 1);
            exp_s = 4'b0;
            if (cur.kind == 2'b10) exp_s = {rd, 1'b0, 1'b0, wr};
            if (cur.kind == 2'b01) exp_s = {1'b0, wr, rd, 1'b0};
            got_s = {mem_rd, mem_wr, io_rd, io_wr};
            check(got_s == exp_s, cur.ext ? "R5" : "R4", "strobes {mrd,mwr,ird,iwr}",
                  int'(got_s), int'(exp_s));
            check(tc == cur.tc, "R7", "tc", int'(tc), int'(cur.tc));
            if (phase == 2) begin
                void'(q.pop_front());
                pend[cur.ch]--;
                phase = -1;
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] m);
        wr(4'd8, m);
        m_mode = m;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [1:0] k, input logic [13:0] c);
        wr(4'(2 * ch), a[7:0]);
        wr(4'(2 * ch), a[15:8]);
        wr(4'(2 * ch + 1), c[7:0]);
        wr(4'(2 * ch + 1), {k, c[13:8]});
        m_addr[ch] = a; m_cnt[ch] = c; m_kind[ch] = k;
    endtask

    // scoreboard producer: predicts one transfer from the requirement model
    task automatic expect_xfer(input int ch);
        xfer_t x;
        x.ch = ch; x.addr = m_addr[ch]; x.kind = m_kind[ch];
        x.tc = (m_cnt[ch] == 14'd1); x.ext = m_mode[5];
        q.push_back(x);
        m_addr[ch] = m_addr[ch] + 16'd1;
        m_cnt[ch]  = m_cnt[ch] - 14'd1;
        if (x.tc) begin
            m_stat[ch] = 1'b1;
            if (ch == 2 && m_mode[7]) begin
                m_addr[2] = m_addr[3]; m_cnt[2] = m_cnt[3]; m_kind[2] = m_kind[3];
                m_stat[4] = 1'b1;
            end else if (m_mode[6]) begin
                m_mode[ch] = 1'b0;
            end
        end
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(q.size() == 0, req, "expected transfers outstanding", q.size(), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_status(input string req);
        logic [7:0] got;
        @(negedge clk);
        cpu_re = 1'b1; cpu_addr = 4'd8;
        #1 got = cpu_rdata;
        @(negedge clk);
        cpu_re = 1'b0;
        check(got == {3'b0, m_stat}, req, "status read", int'(got), int'({3'b0, m_stat}));
        m_stat = '0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (4) @(negedge clk);
        check({hold_req, dack, mem_rd, mem_wr, io_rd, io_wr, tc} == '0, "R1",
              "outputs in reset", int'({hold_req, dack, mem_rd, mem_wr, io_rd, io_wr, tc}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(hold_req == 1'b0, "R1", "hold_req idle", int'(hold_req), 0);
        rd_status("R1");

        // R3 R4 R6 R7: read kind on channel 0, three transfers, last one TC
        set_mode(8'h01);
        prog(0, 16'h1234, 2'b10, 14'd3);
        repeat (3) expect_xfer(0);
        pend[0] = 3;
        @(negedge clk);
        check(hold_req == 1'b1 && dack == 4'b0, "R3", "hold_req one cycle after request",
              int'({hold_req, dack}), 16);
        drain("R3");
        check(hold_req == 1'b0, "R3", "hold released", int'(hold_req), 0);
        rd_status("R7");
        rd_status("R7");

        // R5 R6: write kind with stretched write, address wraps
        set_mode(8'h22);
        prog(1, 16'hFFFF, 2'b01, 14'd2);
        repeat (2) expect_xfer(1);
        pend[1] = 2;
        drain("R5");
        rd_status("R7");

        // R4 verify kind: no strobes
        set_mode(8'h08);
        prog(3, 16'h0040, 2'b00, 14'd1);
        expect_xfer(3);
        pend[3] = 1;
        drain("R4");
        rd_status("R4");

        // R8 stop on terminal count
        set_mode(8'h41);
        prog(0, 16'h0500, 2'b10, 14'd1);
        expect_xfer(0);
        pend[0] = 2;
        drain("R8");
        repeat (20) @(negedge clk);
        check(hold_req == 1'b0, "R8", "no hold after stop", int'(hold_req), 0);
        check(pend[0] == 1, "R8", "requests left unserved", pend[0], 1);
        pend[0] = 0;
        rd_status("R8");

        // R12 disabled channel ignored
        set_mode(8'h01);
        pend[2] = 1;
        repeat (20) @(negedge clk);
        check(hold_req == 1'b0, "R12", "hold for disabled channel", int'(hold_req), 0);
        check(pend[2] == 1, "R12", "disabled channel served", pend[2], 1);
        pend[2] = 0;

        // R9 fixed priority: 0,0,1
        set_mode(8'h03);
        prog(0, 16'h2000, 2'b10, 14'd5);
        prog(1, 16'h3000, 2'b01, 14'd5);
        expect_xfer(0); expect_xfer(0); expect_xfer(1);
        pend[0] = 2; pend[1] = 1;
        drain("R9");

        // R10 rotating priority: last served was 1, so 0,1,0
        set_mode(8'h13);
        expect_xfer(0); expect_xfer(1); expect_xfer(0);
        pend[0] = 2; pend[1] = 1;
        drain("R10");
        rd_status("R10");

        // R11 channel-2 refill from channel 3; channel 3 parked
        set_mode(8'h8C);
        prog(2, 16'h0100, 2'b10, 14'd1);
        prog(3, 16'h0200, 2'b01, 14'd2);
        expect_xfer(2); expect_xfer(2); expect_xfer(2);
        pend[2] = 3; pend[3] = 1;
        drain("R11");
        repeat (10) @(negedge clk);
        check(hold_req == 1'b0, "R11", "channel 3 granted", int'(hold_req), 0);
        check(pend[3] == 1, "R11", "channel 3 served", pend[3], 1);
        pend[3] = 0;
        rd_status("R11");

        // R2 mode write resets byte pointer
        set_mode(8'h01);
        wr(4'd0, 8'h77);
        set_mode(8'h01);
        prog(0, 16'hABCD, 2'b10, 14'd1);
        expect_xfer(0);
        pend[0] = 1;
        drain("R2");
        rd_status("R2");

        finish_run();
    end
endmodule